// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns one instruction fetch address per request into a physical address or a fault code. A TLB lookup sits next to it and supplies hit, frame number and per-mode read-enable bits for the same address in the same cycle. The result is registered and comes out one cycle after the request.

Several paths are checked in a fixed order. Privileged code is marked by a set low address bit and skips translation. A physical-mode request passes straight through. An address outside the valid virtual range is refused. A direct-mapped window is open to kernel mode only. Every other request goes through the TLB hit, miss and permission check. After any of these paths, a result beyond the implemented physical range raises a machine check.

On an access violation or a miss, the fetch address is saved in a fault tag register, and a formatted pointer into the page table is saved with it. Both saves are skipped while the request is marked as misspeculated.

Top module: `fetch_xlate`

## Requirements
- R1: During reset and after it, rsp_valid_o, paddr_o, fault_o, fault_tag_o and fault_form_o are all zero.
- R2: A request sampled at a clock edge gives rsp_valid_o high for the following cycle. Without a request, rsp_valid_o is low and paddr_o and fault_o hold their values. Fault codes are 0 none, 1 access violation, 2 miss and 3 machine check.
- R3: If vaddr_i[0] is 1, paddr_o is vaddr_i with bits 1:0 cleared and masked to its low PA_W (44) bits, and the fault code is 0. Mode, range and TLB inputs have no effect on this path.
- R4: A request with phys_mode_i set and vaddr_i[0] clear gives paddr_o equal to vaddr_i.
- R5: On a translated request (neither of the above), vaddr_i bits 63:42 must all be equal. Otherwise the result is an access violation.
- R6: If spage_en_i[1] is set, vaddr_i[42:41] is 2'b10 and cur_mode_i is 0 (kernel), paddr_o is vaddr_i masked to its low 44 bits and the TLB inputs are ignored. If spage_en_i[1] is clear, the request goes to the TLB.
- R7: A superpage-window request made in any mode other than 0 is an access violation.
- R8: A TLB lookup with tlb_hit_i low gives fault code 2.
- R9: On a hit, paddr_o is {tlb_pfn_i, vaddr_i[12:2], 2'b00}. If tlb_rd_en_i[cur_mode_i] is 0, the result is an access violation.
- R10: A result with any bit at or above PA_W set gives fault code 3 and leaves the fault registers unchanged.
- R11: On an access violation or miss with misspec_i low, fault_tag_o takes vaddr_i and fault_form_o takes ptbr_i | (vaddr_i[42:13] << 3).
- R12: While misspec_i is high, the fault registers keep their values. The fault code is still reported.
- R13: Whenever fault_o is nonzero with rsp_valid_o high, paddr_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Translation request |
| vaddr_i | input | VA_W | Fetch address |
| phys_mode_i | input | 1 | Request is already physical |
| spage_en_i | input | 2 | Superpage enables; bit 1 opens the window |
| cur_mode_i | input | MODE_W | Current privilege mode, 0 is kernel |
| misspec_i | input | 1 | Request is misspeculated |
| ptbr_i | input | VA_W | Page-table base for the formatted pointer |
| tlb_hit_i | input | 1 | TLB lookup hit |
| tlb_pfn_i | input | PA_W-PG_W | Frame number of the hit entry |
| tlb_rd_en_i | input | NMODE | Per-mode read enables of the hit entry |
| rsp_valid_o | output | 1 | Result valid |
| paddr_o | output | VA_W | Physical address |
| fault_o | output | 2 | Fault code |
| fault_tag_o | output | VA_W | Captured faulting address |
| fault_form_o | output | VA_W | Captured formatted page-table pointer |

## Verification
The path priority decides what a fetch returns, so the wrong state is easy to see: a path chosen in the wrong order, such as the TLB consulted inside the superpage window or the privileged bypass lost, shows up as a wrong paddr_o or fault_o in the cycle right after the request. A fault register loaded at the wrong time shows up only later. The bench therefore reads fault_tag_o and fault_form_o after every request, including misspeculated and machine-check ones. Reset and idle cycles are checked on the outputs directly.

// File: rtl/fetch_xlate_pkg.sv
package fetch_xlate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_ACV  = 2'd1,
    FLT_MISS = 2'd2,
    FLT_MCHK = 2'd3
  } flt_e;
endpackage

// File: rtl/fetch_xlate_path.sv
module fetch_xlate_path
  import fetch_xlate_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int VA_IMPL_W = 43,
  parameter int PA_W      = 44,
  parameter int PG_W      = 13,
  parameter int NMODE     = 4,
  localparam int PFN_W    = PA_W - PG_W,
  localparam int MODE_W   = $clog2(NMODE)
) (
  input  logic [VA_W-1:0]   va_i,
  input  logic              phys_i,
  input  logic [1:0]        sp_en_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              hit_i,
  input  logic [PFN_W-1:0]  pfn_i,
  input  logic [NMODE-1:0]  rd_en_i,
  output logic [VA_W-1:0]   pa_o,
  output flt_e              flt_o
);
  localparam logic [VA_W-1:0] IMPL_MASK = {{(VA_W-PA_W){1'b0}}, {PA_W{1'b1}}};

  logic va_ok;
  generate
    if (VA_IMPL_W < VA_W) begin : g_range
      logic [VA_W-VA_IMPL_W:0] upper;
      assign upper = va_i[VA_W-1:VA_IMPL_W-1];
      assign va_ok = (&upper) | ~(|upper);
    end else begin : g_full
      assign va_ok = 1'b1;
    end
  endgenerate

  logic            in_window;
  logic [VA_W-1:0] pa_raw;
  flt_e            flt_raw;

  assign in_window = sp_en_i[1] && (va_i[VA_IMPL_W-1 -: 2] == 2'b10);

  // priority: privileged PC, physical, range, superpage, TLB
  always_comb begin
    pa_raw  = '0;
    flt_raw = FLT_NONE;
    if (va_i[0]) begin
      pa_raw = {va_i[VA_W-1:2], 2'b00} & IMPL_MASK;
    end else if (phys_i) begin
      pa_raw = va_i;
    end else if (!va_ok) begin
      flt_raw = FLT_ACV;
    end else if (in_window) begin
      if (mode_i != '0) flt_raw = FLT_ACV;
      else              pa_raw  = va_i & IMPL_MASK;
    end else if (!hit_i) begin
      flt_raw = FLT_MISS;
    end else begin
      pa_raw = {{(VA_W-PA_W){1'b0}}, pfn_i, va_i[PG_W-1:2], 2'b00};
      if (!rd_en_i[mode_i]) flt_raw = FLT_ACV;
    end
  end

  always_comb begin
    flt_o = flt_raw;
    if (flt_raw == FLT_NONE && (|pa_raw[VA_W-1:PA_W])) flt_o = FLT_MCHK;
    pa_o = (flt_o == FLT_NONE) ? pa_raw : '0;
  end
endmodule

// File: rtl/fetch_xlate_capture.sv
module fetch_xlate_capture
  import fetch_xlate_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int VA_IMPL_W = 43,
  parameter int PG_W      = 13,
  parameter int PTE_SH    = 3,
  localparam int VPN_W    = VA_IMPL_W - PG_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            misspec_i,
  input  flt_e            flt_i,
  input  logic [VA_W-1:0] va_i,
  input  logic [VA_W-1:0] ptbr_i,
  output logic [VA_W-1:0] tag_o,
  output logic [VA_W-1:0] form_o
);
  logic [VPN_W-1:0] vpn;
  logic [VA_W-1:0]  form_nxt;
  logic             load;

  assign vpn      = va_i[VA_IMPL_W-1:PG_W];
  assign form_nxt = ptbr_i | ({{(VA_W-VPN_W){1'b0}}, vpn} << PTE_SH);
  // machine checks do not load the fault registers
  assign load     = req_i && !misspec_i && (flt_i == FLT_ACV || flt_i == FLT_MISS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_o  <= '0;
      form_o <= '0;
    end else if (load) begin
      tag_o  <= va_i;
      form_o <= form_nxt;
    end
  end
endmodule

// File: rtl/fetch_xlate.sv
module fetch_xlate
  import fetch_xlate_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int VA_IMPL_W = 43,
  parameter int PA_W      = 44,
  parameter int PG_W      = 13,
  parameter int NMODE     = 4,
  parameter int PTE_SH    = 3,
  localparam int PFN_W    = PA_W - PG_W,
  localparam int MODE_W   = $clog2(NMODE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic              phys_mode_i,
  input  logic [1:0]        spage_en_i,
  input  logic [MODE_W-1:0] cur_mode_i,
  input  logic              misspec_i,
  input  logic [VA_W-1:0]   ptbr_i,
  input  logic              tlb_hit_i,
  input  logic [PFN_W-1:0]  tlb_pfn_i,
  input  logic [NMODE-1:0]  tlb_rd_en_i,
  output logic              rsp_valid_o,
  output logic [VA_W-1:0]   paddr_o,
  output logic [1:0]        fault_o,
  output logic [VA_W-1:0]   fault_tag_o,
  output logic [VA_W-1:0]   fault_form_o
);
  logic [VA_W-1:0] pa_d;
  flt_e            flt_d;

  fetch_xlate_path #(
    .VA_W(VA_W), .VA_IMPL_W(VA_IMPL_W), .PA_W(PA_W), .PG_W(PG_W), .NMODE(NMODE)
  ) u_path (
    .va_i(vaddr_i), .phys_i(phys_mode_i), .sp_en_i(spage_en_i), .mode_i(cur_mode_i),
    .hit_i(tlb_hit_i), .pfn_i(tlb_pfn_i), .rd_en_i(tlb_rd_en_i),
    .pa_o(pa_d), .flt_o(flt_d)
  );

  fetch_xlate_capture #(
    .VA_W(VA_W), .VA_IMPL_W(VA_IMPL_W), .PG_W(PG_W), .PTE_SH(PTE_SH)
  ) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .misspec_i(misspec_i),
    .flt_i(flt_d), .va_i(vaddr_i), .ptbr_i(ptbr_i),
    .tag_o(fault_tag_o), .form_o(fault_form_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      paddr_o     <= '0;
      fault_o     <= FLT_NONE;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        paddr_o <= pa_d;
        fault_o <= flt_d;
      end
    end
  end
endmodule

// File: rtl/fetch_xlate_chk.sv
module fetch_xlate_chk #(
  parameter int VA_W = 64,
  parameter int PA_W = 44
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic [VA_W-1:0] vaddr_i,
  input logic            misspec_i,
  input logic            rsp_valid_o,
  input logic [VA_W-1:0] paddr_o,
  input logic [1:0]      fault_o,
  input logic [VA_W-1:0] fault_tag_o
);
  a_r2_rsp_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);

  a_r2_idle_no_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o);

  a_r3_priv_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && vaddr_i[0]) |=> (fault_o == 2'd0 && paddr_o[1:0] == 2'b00));

  a_r10_pa_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && fault_o == 2'd0) |-> (paddr_o[VA_W-1:PA_W] == '0));

  a_r13_fault_pa_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && fault_o != 2'd0) |-> (paddr_o == '0));

  a_r11_tag_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !misspec_i) |=>
      ((fault_o != 2'd1 && fault_o != 2'd2) || fault_tag_o == $past(vaddr_i)));

  a_r12_tag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || misspec_i) |=> $stable(fault_tag_o));
endmodule

bind fetch_xlate fetch_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .vaddr_i(vaddr_i),
  .misspec_i(misspec_i), .rsp_valid_o(rsp_valid_o), .paddr_o(paddr_o),
  .fault_o(fault_o), .fault_tag_o(fault_tag_o)
);

// File: tb/sim_fetch_xlate.sv
`timescale 1ns/1ps
module sim_fetch_xlate;
  localparam logic [63:0] PTBR  = 64'h0000_0100_0000_0000;
  localparam logic [63:0] VA_SP = 64'hFFFF_FC00_1234_5678;

  typedef struct packed {
    logic [63:0] va;
    logic        phys;
    logic [1:0]  spen;
    logic [1:0]  mode;
    logic        misspec;
    logic        hit;
    logic [30:0] pfn;
    logic [3:0]  rden;
    logic [63:0] pa;
    logic [1:0]  flt;
    logic        cap;
    logic [23:0] rq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0000_0000_1007, 1'b0, 2'b00, 2'd3, 1'b0, 1'b0, 31'd0, 4'h0, 64'h0000_0000_0000_1004, 2'd0, 1'b0, "R3 "},
    '{64'hFFF0_0000_0000_2003, 1'b0, 2'b00, 2'd3, 1'b0, 1'b0, 31'd0, 4'h0, 64'h0000_0000_0000_2000, 2'd0, 1'b0, "R3 "},
    '{64'h0000_0ABC_DEF0_1230, 1'b1, 2'b00, 2'd3, 1'b0, 1'b0, 31'd0, 4'h0, 64'h0000_0ABC_DEF0_1230, 2'd0, 1'b0, "R4 "},
    '{64'h0001_0000_0000_0000, 1'b1, 2'b00, 2'd0, 1'b0, 1'b0, 31'd0, 4'h0, 64'h0,                   2'd3, 1'b0, "R10"},
    '{64'h0000_8000_0000_0000, 1'b0, 2'b10, 2'd0, 1'b0, 1'b1, 31'd1, 4'hF, 64'h0,                   2'd1, 1'b1, "R5 "},
    '{VA_SP,                   1'b0, 2'b10, 2'd0, 1'b0, 1'b0, 31'd0, 4'h0, 64'h0000_0C00_1234_5678, 2'd0, 1'b0, "R6 "},
    '{VA_SP,                   1'b0, 2'b10, 2'd3, 1'b0, 1'b1, 31'h155, 4'hF, 64'h0,                 2'd1, 1'b1, "R7 "},
    '{VA_SP,                   1'b0, 2'b01, 2'd0, 1'b0, 1'b1, 31'h155, 4'hF, 64'h0000_0000_002A_B678, 2'd0, 1'b0, "R6 "},
    '{64'h0000_0000_0040_A000, 1'b0, 2'b00, 2'd0, 1'b0, 1'b0, 31'd0, 4'hF, 64'h0,                   2'd2, 1'b1, "R8 "},
    '{64'h0000_0000_0077_0000, 1'b0, 2'b00, 2'd0, 1'b1, 1'b0, 31'd0, 4'hF, 64'h0,                   2'd2, 1'b0, "R12"},
    '{64'h0000_0012_3456_789C, 1'b0, 2'b00, 2'd3, 1'b0, 1'b1, 31'h7FFF_FFFF, 4'b1000, 64'h0000_0FFF_FFFF_F89C, 2'd0, 1'b0, "R9 "},
    '{64'h0000_0012_3456_789C, 1'b0, 2'b00, 2'd2, 1'b0, 1'b1, 31'h7FFF_FFFF, 4'b1011, 64'h0,         2'd1, 1'b1, "R9 "},
    '{64'h0000_0000_0000_600A, 1'b0, 2'b00, 2'd0, 1'b0, 1'b1, 31'd1, 4'b0001, 64'h0000_0000_0000_2008, 2'd0, 1'b0, "R9 "}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0;
  logic [63:0] vaddr = '0;
  logic        phys = 1'b0;
  logic [1:0]  spen = '0;
  logic [1:0]  mode = '0;
  logic        misspec = 1'b0;
  logic        hit = 1'b0;
  logic [30:0] pfn = '0;
  logic [3:0]  rden = '0;
  logic        rsp_valid;
  logic [63:0] paddr, ftag, fform;
  logic [1:0]  fault;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_tag = '0;
  logic [63:0] exp_form = '0;

  always #4 clk = ~clk;

  fetch_xlate u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .vaddr_i(vaddr), .phys_mode_i(phys),
    .spage_en_i(spen), .cur_mode_i(mode), .misspec_i(misspec), .ptbr_i(PTBR),
    .tlb_hit_i(hit), .tlb_pfn_i(pfn), .tlb_rd_en_i(rden),
    .rsp_valid_o(rsp_valid), .paddr_o(paddr), .fault_o(fault),
    .fault_tag_o(ftag), .fault_form_o(fform)
  );

  function automatic logic [63:0] form_of(logic [63:0] va);
    return PTBR | ({34'd0, va[42:13]} << 3);
  endfunction

  task automatic check(string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    @(negedge clk);
    req = 1'b1; vaddr = v.va; phys = v.phys; spen = v.spen; mode = v.mode;
    misspec = v.misspec; hit = v.hit; pfn = v.pfn; rden = v.rden;
    @(negedge clk);
    req = 1'b0;
    if (v.cap) begin
      exp_tag  = v.va;
      exp_form = form_of(v.va);
    end
    check(string'(v.rq), "valid", {63'd0, rsp_valid}, 64'd1);
    check(string'(v.rq), "paddr", paddr, v.pa);
    check(string'(v.rq), "fault", {62'd0, fault}, {62'd0, v.flt});
    check(v.cap ? "R11" : string'(v.rq), "tag", ftag, exp_tag);
    check(v.cap ? "R11" : string'(v.rq), "form", fform, exp_form);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R1 reset values, during and after reset
    check("R1", "valid", {63'd0, rsp_valid}, 64'd0);
    check("R1", "paddr", paddr, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", "fault", {62'd0, fault}, 64'd0);
    check("R1", "tag", ftag, 64'd0);
    check("R1", "form", fform, 64'd0);

    for (int i = 0; i < NV; i++) apply(VECS[i]);

    // R2: idle cycle keeps the outputs and drops valid
    held = paddr;
    @(negedge clk);
    check("R2", "idle valid", {63'd0, rsp_valid}, 64'd0);
    check("R2", "idle paddr", paddr, held);

    // R12: misspeculated violation keeps the tag and reports the code
    apply('{64'h0000_0000_0000_4000, 1'b0, 2'b00, 2'd1, 1'b1, 1'b1, 31'd3, 4'b0000,
            64'h0, 2'd1, 1'b0, "R12"});
    // R13: miss with phys not set gives zero address
    apply('{64'h0000_0000_1000_0000, 1'b0, 2'b10, 2'd0, 1'b0, 1'b0, 31'd0, 4'hF,
            64'h0, 2'd2, 1'b1, "R13"});

    // R1: asynchronous reset mid-run clears the fault registers
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1", "tag after reset", ftag, 64'd0);
    check("R1", "form after reset", fform, 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule